// File: doc/BRIEF.md
# Real-Time Clock Register Interface

This block gives a host indexed access to a small bank of clock registers. It uses one byte-wide bus with two ports. The index port selects a register and the data port reads or writes the selected register. The host writes an index first. Every later data access goes to that index until the host writes a new one. Indices 0x0 to 0x9 are plain storage bytes for time and date values; the block never advances them on its own. Indices 0xA to 0xD are status registers, and each has its own rules.

A periodic tick counter runs while the periodic-interrupt enable in status register B is set. Each time it completes its interval it emits a single-cycle interrupt pulse, then starts counting the next interval. Writing register B starts or stops this counter.

Any access the block does not support is refused. The register it targets keeps its value, and a single-cycle error pulse is raised. Read data comes back one cycle after the read request, together with a valid strobe.

Top module: `rtc_regif`

## Requirements
- R1: An index write with a value of 0x0D or less is taken as the new index. An index write with a larger value raises `acc_err` for one cycle and leaves the index unchanged. A read of the index port returns the current index in bits 3:0, with zeros in bits 7:4.
- R2: Indices 0x0 to 0x9 are read/write storage bytes, all 0x00 after reset. A read of the data port returns the selected byte on `bus_rdata`, with `bus_rvalid` high in the cycle after the request.
- R3: After reset, status register A holds 0x26. Bits 6:4 = 010 select the 32.768 kHz time base, bits 3:0 = 0110 select the 1024 Hz rate, and bit 7 is update-in-progress.
- R4: After reset, status register B holds 0x46. Bit 6 is the periodic-interrupt enable, bit 2 selects binary data and bit 1 selects 24-hour mode. The periodic timer is running out of reset.
- R5: Each read of register A first inverts bit 7 of the stored value and then returns the new value. The first read after reset therefore returns 0xA6 and the next read returns 0x26.
- R6: A write to register B is accepted when its value, with bits 6 and 3 masked off, equals 0x06.
  - An accepted write with bit 6 set starts the timer if it is stopped; the first pulse then follows exactly TICK_CYCLES cycles after the write. If the timer is already running, it keeps its phase.
  - An accepted write with bit 6 clear stops the timer. If such a write lands on the same cycle as an expiry, the stop wins and no pulse is emitted.
- R7: While the timer runs, `pi_irq` is high for exactly one cycle every TICK_CYCLES cycles.
- R8: Registers C (0x0C) and D (0x0D) always read as 0x00. Writes to them raise `acc_err` and change nothing.
- R9: A write to register A with a value other than 0x26 raises `acc_err` and leaves A unchanged. A write of 0x26 is accepted, leaving bit 7 clear. A write to register B with unsupported bits raises `acc_err` and leaves both B and the timer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_port | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read request |
| acc_err | output | 1 | One-cycle pulse for a refused access |
| pi_irq | output | 1 | One-cycle periodic interrupt pulse |

## Verification
Two functions can meet in one cycle: expiry of the tick counter and a host write to register B that starts or stops it. The bench locks onto an observed pulse and counts cycles forward. It then lands the register B write exactly on the edge of the next expiry.

A clearing write at that edge must suppress the pulse, and no pulse may follow. An enabling write to a running timer must let the pulse through at that edge, and the phase must be kept. The next pulse must come exactly one interval later.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned IDX_W    = 4;
   localparam int unsigned IDX_A    = 10;
   localparam int unsigned IDX_B    = 11;
   localparam int unsigned IDX_C    = 12;
   localparam int unsigned IDX_D    = 13;
   localparam int unsigned IDX_TOP  = IDX_D;
   localparam int unsigned UIP_POS  = 7;
   localparam int unsigned PIE_POS  = 6;
   localparam int unsigned SQW_POS  = 3;
   localparam logic [BYTE_W-1:0] A_RESET  = 8'h26;
   localparam logic [BYTE_W-1:0] B_RESET  = 8'h46;
   localparam logic [BYTE_W-1:0] B_FIXED  = 8'h06;
   localparam logic [BYTE_W-1:0] UIP_MASK = BYTE_W'(1 << UIP_POS);
   localparam logic [BYTE_W-1:0] B_FREE   = BYTE_W'((1 << PIE_POS) | (1 << SQW_POS));

   typedef enum logic {
      PORT_INDEX = 1'b0,
      PORT_DATA  = 1'b1
   } port_e;
endpackage

// File: rtl/rtc_index_reg.sv
module rtc_index_reg
   import rtc_pkg::*;
#(
   parameter int unsigned W   = IDX_W,
   parameter int unsigned TOP = IDX_TOP
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [W-1:0]      idx_q,
   output logic              reject
);
   localparam logic [BYTE_W-1:0] TOP_B = BYTE_W'(TOP);

   if (TOP >= (1 << W)) begin : g_bad_width
      $error("rtc_index_reg: index width too small for TOP");
   end

   logic over;
   assign over   = wdata > TOP_B;
   assign reject = wr && over;

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx_q <= '0;
      else if (wr && !over)
         idx_q <= wdata[W-1:0];
   end

   // R1
   bad_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && over) |=> $stable(idx_q));
endmodule

// File: rtl/rtc_time_store.sv
module rtc_time_store
   import rtc_pkg::*;
#(
   parameter int unsigned N = IDX_A,
   parameter int unsigned W = IDX_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [W-1:0]      idx,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rd_byte
);
   if (N == 0 || N > (1 << W)) begin : g_bad_depth
      $error("rtc_time_store: depth out of range");
   end

   logic [BYTE_W-1:0] mem [N];

   for (genvar g = 0; g < N; g++) begin : g_byte
      always_ff @(posedge clk) begin
         if (!rst_n)
            mem[g] <= '0;
         else if (wr && idx == W'(g))
            mem[g] <= wdata;
      end
   end

   always_comb begin
      rd_byte = '0;
      for (int i = 0; i < N; i++)
         if (idx == W'(i))
            rd_byte = mem[i];
   end

   // R2
   store_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (idx != $past(idx)) || (rd_byte == $past(wdata)));
endmodule

// File: rtl/rtc_status.sv
module rtc_status
   import rtc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [IDX_W-1:0]  idx,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rd_val,
   output logic              reject,
   output logic              pie_start,
   output logic              pie_stop
);
   logic sel_a, sel_b, sel_cd;
   logic a_ok, b_ok;
   logic [BYTE_W-1:0] reg_a, reg_b;

   assign sel_a  = idx == IDX_W'(IDX_A);
   assign sel_b  = idx == IDX_W'(IDX_B);
   assign sel_cd = (idx == IDX_W'(IDX_C)) || (idx == IDX_W'(IDX_D));
   assign a_ok   = wdata == A_RESET;
   assign b_ok   = (wdata & ~B_FREE) == B_FIXED;

   assign reject    = wr && ((sel_a && !a_ok) || (sel_b && !b_ok) || sel_cd);
   assign pie_start = wr && sel_b && b_ok &&  wdata[PIE_POS];
   assign pie_stop  = wr && sel_b && b_ok && !wdata[PIE_POS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_a <= A_RESET;
         reg_b <= B_RESET;
      end else begin
         if (rd && sel_a)
            reg_a <= reg_a ^ UIP_MASK;
         else if (wr && sel_a && a_ok)
            reg_a <= wdata;
         if (wr && sel_b && b_ok)
            reg_b <= wdata;
      end
   end

   always_comb begin
      if (sel_a)      rd_val = reg_a ^ UIP_MASK;
      else if (sel_b) rd_val = reg_b;
      else            rd_val = '0;
   end

   // R5
   uip_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && sel_a) |=> reg_a[UIP_POS] != $past(reg_a[UIP_POS]));
   // R9
   a_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel_a && wdata != A_RESET) |=> $stable(reg_a));
   // R9
   b_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel_b && !b_ok) |=> $stable(reg_b));
endmodule

// File: rtl/rtc_tick.sv
module rtc_tick #(
   parameter int unsigned TICK_CYCLES = 32
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic stop,
   output logic irq
);
   localparam int unsigned CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_CYCLES - 1);

   if (TICK_CYCLES < 2) begin : g_bad_tick
      $error("rtc_tick: TICK_CYCLES must be at least 2");
   end

   logic             running;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b1;
         cnt     <= '0;
         irq     <= 1'b0;
      end else if (stop) begin
         running <= 1'b0;
         cnt     <= '0;
         irq     <= 1'b0;
      end else if (start && !running) begin
         running <= 1'b1;
         cnt     <= '0;
         irq     <= 1'b0;
      end else if (running) begin
         if (cnt == CNT_LAST) begin
            cnt <= '0;
            irq <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
            irq <= 1'b0;
         end
      end else begin
         irq <= 1'b0;
      end
   end

   // R7
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R6
   stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !irq && !running);
   // R6
   start_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !stop && !running) |=> running && !irq);
endmodule

// File: rtl/rtc_regif.sv
module rtc_regif
   import rtc_pkg::*;
#(
   parameter int unsigned TICK_CYCLES = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic              bus_port,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic              bus_rvalid,
   output logic              acc_err,
   output logic              pi_irq
);
   localparam int unsigned TIME_BYTES = IDX_A;

   logic wr_idx, rd_idx, wr_dat, rd_dat, in_time;
   logic [IDX_W-1:0]  idx;
   logic [BYTE_W-1:0] store_byte, stat_byte;
   logic idx_reject, stat_reject, pie_start, pie_stop;

   assign wr_idx  = bus_en &&  bus_we && (bus_port == PORT_INDEX);
   assign rd_idx  = bus_en && !bus_we && (bus_port == PORT_INDEX);
   assign wr_dat  = bus_en &&  bus_we && (bus_port == PORT_DATA);
   assign rd_dat  = bus_en && !bus_we && (bus_port == PORT_DATA);
   assign in_time = idx < IDX_W'(TIME_BYTES);

   rtc_index_reg #(.W(IDX_W), .TOP(IDX_TOP)) u_index (
      .clk(clk), .rst_n(rst_n), .wr(wr_idx), .wdata(bus_wdata),
      .idx_q(idx), .reject(idx_reject)
   );

   rtc_time_store #(.N(TIME_BYTES), .W(IDX_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr(wr_dat && in_time), .idx(idx),
      .wdata(bus_wdata), .rd_byte(store_byte)
   );

   rtc_status u_status (
      .clk(clk), .rst_n(rst_n), .wr(wr_dat && !in_time),
      .rd(rd_dat && !in_time), .idx(idx), .wdata(bus_wdata),
      .rd_val(stat_byte), .reject(stat_reject),
      .pie_start(pie_start), .pie_stop(pie_stop)
   );

   rtc_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
      .clk(clk), .rst_n(rst_n), .start(pie_start), .stop(pie_stop),
      .irq(pi_irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
         acc_err    <= 1'b0;
      end else begin
         bus_rvalid <= rd_idx || rd_dat;
         acc_err    <= idx_reject || stat_reject;
         if (rd_idx)
            bus_rdata <= {{(BYTE_W-IDX_W){1'b0}}, idx};
         else if (rd_dat)
            bus_rdata <= in_time ? store_byte : stat_byte;
      end
   end

   // R8
   cd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_dat && idx >= IDX_W'(IDX_C)) |=> bus_rdata == '0);
   // R2
   read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_dat || rd_idx) |=> bus_rvalid);
endmodule

// File: tb/rtc_regif_bench.sv
module rtc_regif_bench;
   localparam int CLK_PERIOD = 10;
   localparam int TICK = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_en = 1'b0, bus_we = 1'b0, bus_port = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       bus_rvalid, acc_err, pi_irq;

   int cyc = 0;
   int n_run = 0;
   int n_fail = 0;
   logic [7:0] rd_v;
   logic       err_v, rv_v;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rtc_regif #(.TICK_CYCLES(TICK)) u_rtc_regif (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .acc_err(acc_err), .pi_irq(pi_irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // called at a negedge, returns at the next negedge with results captured
   task automatic access(input logic port, input logic we, input logic [7:0] d);
      bus_en = 1'b1; bus_we = we; bus_port = port; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
      rd_v = bus_rdata; err_v = acc_err; rv_v = bus_rvalid;
   endtask

   task automatic wr_idx(input logic [7:0] d); access(1'b0, 1'b1, d); endtask
   task automatic wr_dat(input logic [7:0] d); access(1'b1, 1'b1, d); endtask
   task automatic rd_dat(); access(1'b1, 1'b0, 8'h00); endtask
   task automatic rd_idx(); access(1'b0, 1'b0, 8'h00); endtask

   task automatic wait_irq(output int at);
      at = -1;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (pi_irq) begin at = cyc; break; end
      end
   endtask

   task automatic t_reset();
      chk("R2 reset rdata", bus_rdata, 0);
      chk("R2 reset rvalid", bus_rvalid, 0);
      chk("R1 reset err", acc_err, 0);
      chk("R7 reset irq", pi_irq, 0);
      rst_n = 1'b1;
      @(negedge clk);
      wr_idx(8'h0B); rd_dat();
      chk("R4 B reset", rd_v, 8'h46);
      wr_idx(8'h0A); rd_dat();
      chk("R3 A reset first read", rd_v, 8'hA6);
      rd_dat();
      chk("R5 A second read", rd_v, 8'h26);
      rd_dat();
      chk("R5 A third read", rd_v, 8'hA6);
      for (int i = 0; i < 10; i++) begin
         wr_idx(8'(i)); rd_dat();
         chk("R2 store reset zero", rd_v, 0);
         chk("R2 read valid", rv_v, 1);
      end
   endtask

   task automatic t_period();
      int p1, p2;
      wait_irq(p1);
      @(negedge clk);
      chk("R7 pulse one cycle", pi_irq, 0);
      wait_irq(p2);
      chk("R7 period", p2 - p1, TICK);
   endtask

   task automatic t_collide_start();
      int p, q;
      wr_idx(8'h0B);
      wait_irq(p);
      repeat (TICK - 1) @(negedge clk);
      wr_dat(8'h46);
      chk("R6 enable at expiry keeps pulse", pi_irq, 1);
      chk("R6 enable accepted", err_v, 0);
      wait_irq(q);
      chk("R6 phase kept", q - p, 2 * TICK);
   endtask

   task automatic t_collide_stop();
      int p, seen;
      wait_irq(p);
      repeat (TICK - 1) @(negedge clk);
      wr_dat(8'h06);
      chk("R6 stop at expiry suppresses pulse", pi_irq, 0);
      seen = 0;
      for (int i = 0; i < 3 * TICK; i++) begin
         @(negedge clk);
         if (pi_irq) seen++;
      end
      chk("R6 stopped no pulses", seen, 0);
      rd_dat();
      chk("R6 B after stop", rd_v, 8'h06);
   endtask

   task automatic t_start();
      int w, q;
      wr_dat(8'h46);
      w = cyc;
      wait_irq(q);
      chk("R6 first pulse after start", q - w, TICK);
      wr_dat(8'h4E);
      chk("R6 square-wave bit accepted", err_v, 0);
      rd_dat();
      chk("R6 B readback", rd_v, 8'h4E);
      wr_dat(8'h47);
      chk("R9 bad B err", err_v, 1);
      rd_dat();
      chk("R9 B unchanged", rd_v, 8'h4E);
      wait_irq(w);
      wait_irq(q);
      chk("R9 timer unaffected", q - w, TICK);
   endtask

   task automatic t_cd();
      for (int r = 12; r <= 13; r++) begin
         wr_idx(8'(r));
         chk("R1 idx C/D accepted", err_v, 0);
         rd_dat();
         chk("R8 C/D read zero", rd_v, 0);
         wr_dat(8'hFF);
         chk("R8 C/D write err", err_v, 1);
         rd_dat();
         chk("R8 C/D still zero", rd_v, 0);
      end
   endtask

   task automatic t_reg_a();
      wr_idx(8'h0A);
      wr_dat(8'h26);
      chk("R9 A good write", err_v, 0);
      rd_dat();
      chk("R9 A after write", rd_v, 8'hA6);
      wr_dat(8'h00);
      chk("R9 A bad write err", err_v, 1);
      rd_dat();
      chk("R9 A unchanged", rd_v, 8'h26);
   endtask

   task automatic t_index();
      wr_idx(8'h05);
      wr_idx(8'h0E);
      chk("R1 index reject err", err_v, 1);
      rd_idx();
      chk("R1 index kept", rd_v, 8'h05);
      wr_dat(8'h5A);
      rd_dat();
      chk("R1 data to kept index", rd_v, 8'h5A);
      wr_idx(8'hFF);
      chk("R1 index FF err", err_v, 1);
      wr_idx(8'h0D);
      chk("R1 index D ok", err_v, 0);
      rd_idx();
      chk("R1 index read D", rd_v, 8'h0D);
   endtask

   task automatic t_store();
      for (int i = 0; i < 10; i++) begin
         wr_idx(8'(i)); wr_dat(8'(8'h31 * (i + 1)));
         chk("R2 store write no err", err_v, 0);
      end
      for (int i = 9; i >= 0; i--) begin
         wr_idx(8'(i)); rd_dat();
         chk("R2 store readback", rd_v, 8'(8'h31 * (i + 1)));
      end
      wr_dat(8'h00);
      chk("R2 no rvalid on write", rv_v, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_period();
      t_collide_start();
      t_collide_stop();
      t_start();
      t_cd();
      t_reg_a();
      t_index();
      t_store();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule